// File: doc/BRIEF.md
# Repeater Hash Message Packer

This block assembles the message that a repeater-verification hash engine digests and hands it out one 32-bit word at a time over a valid/ready handshake. A run is launched with a downstream device count and a 16-bit downstream status word. The 40-bit key of each downstream device then arrives over a key handshake. Keys are laid end to end and packed big-endian, so a key may straddle two words.

Each emitted word carries a mode code telling the engine how many of its bits are message text. Where the text runs short, the engine supplies the remaining bits from its 64-bit secret value itself. After the keys the block appends the status word, then the secret region, then zero padding up to the last word of a 64-byte block. It then emits the message length in bits and a final "complete" beat. It waits for the engine's completion flag and reports pass or fail from the engine's match flag.

The split of the status word and the secret region across words follows one of four fixed patterns. The pattern is chosen by how many bytes of the last key are left over in a partly filled word.

Top module: `hash_msg_packer`

## Requirements
- R1: Key bytes are concatenated in arrival order, most significant byte of each key first, and packed into words with the earliest byte in bits 31:24. Every word that holds only key bytes carries mode 1 (32 text bits). While a key is being accepted, no word is offered.
- R2: When 5×count is a multiple of 4 (no leftover byte), the tail words are {16'h0, status} with mode 5, then zero with mode 7, then zero with mode 5.
- R3: With one leftover byte b, the tail words are {8'h0, b, status} with mode 4, then zero with mode 7, then zero with mode 6.
- R4: With two leftover bytes b0 and b1, the tail words are {b0, b1, status} with mode 1, then two zero words with mode 7.
- R5: With three leftover bytes b0, b1 and b2, the tail words are {b0, b1, b2, status[15:8]} with mode 1, then {24'h0, status[7:0]} with mode 6, then zero with mode 7, then zero with mode 4.
- R6: After the tail, zero words with mode 1 follow until the count of words emitted so far is 15 modulo 16. The next word carries (count×5+10)×8 with mode 1.
- R7: After the length word the block emits one beat with mode 2 and data zero. It then raises `done` for one cycle, with `pass` equal to `hash_match`, in the cycle after `hash_done` is seen high, and not before.
- R8: A count of zero emits no words, takes no keys, and gives `done` with `pass`=1 and `err`=0 one cycle after `start`.
- R9: A count above MAX_COUNT (127) takes no keys and emits no words. It gives `done` with `err`=1 and `pass`=0 one cycle after `start`.
- R10: While `word_valid` is high and `word_ready` is low, `word_valid`, `word_data` and `word_mode` keep their values.
- R11: After reset, `word_valid`, `key_ready` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a run when idle |
| dev_count | input | 8 | Number of downstream keys |
| dev_status | input | 16 | Downstream status word |
| key_valid | input | 1 | Key offered |
| key_data | input | 40 | Device key, first byte in bits 39:32 |
| key_ready | output | 1 | Key accepted when both are high |
| word_valid | output | 1 | Message word offered |
| word_ready | input | 1 | Engine accepts word |
| word_data | output | 32 | Message word, big-endian |
| word_mode | output | 3 | Text-width code for the word |
| hash_done | input | 1 | Engine finished the digest |
| hash_match | input | 1 | Digest equals the receiver's value |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run result, valid with done |
| err | output | 1 | Count out of range, valid with done |

## Verification
A wrong leftover count after the keys picks the wrong one of the four tail patterns, so the first tail word shows a wrong mode or misplaced status bytes. A byte-buffer fault shows up within one word as misordered key bytes. A slipped word counter shifts the padding, so the length word arrives one or more beats early or late. This is visible at the port within at most sixteen beats. A stuck wait state shows as `done` arriving before `hash_done`, or never.

// File: rtl/hash_msg_packer.sv
module hash_msg_packer #(
  parameter int CNT_W     = 8,
  parameter int MAX_COUNT = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] dev_count,
  input  logic [15:0]      dev_status,
  input  logic             key_valid,
  input  logic [39:0]      key_data,
  output logic             key_ready,
  output logic             word_valid,
  input  logic             word_ready,
  output logic [31:0]      word_data,
  output logic [2:0]       word_mode,
  input  logic             hash_done,
  input  logic             hash_match,
  output logic             done,
  output logic             pass,
  output logic             err
);

  localparam logic [2:0] M_T32 = 3'd1, M_CMPL = 3'd2, M_T24 = 3'd4,
                         M_T16 = 3'd5, M_T8 = 3'd6, M_T0 = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_KEYS, S_TAIL, S_PAD, S_LEN, S_CMPL, S_WAIT, S_DONE} st_t;

  st_t              state;
  logic [CNT_W-1:0] left, total;
  logic [15:0]      stat_q;
  logic [63:0]      acc;
  logic [3:0]       nb;
  logic [1:0]       tidx;
  logic [3:0]       wcnt;
  logic             pass_q, err_q;
  logic [31:0]      tail_data;
  logic [2:0]       tail_mode;
  logic             tail_last;
  logic             fire, push;

  wire [7:0] b0 = acc[63:56];
  wire [7:0] b1 = acc[55:48];
  wire [7:0] b2 = acc[47:40];
  wire [7:0] s0 = stat_q[15:8];
  wire [7:0] s1 = stat_q[7:0];
  wire [31:0] len_bits = 32'(total) * 32'd40 + 32'd80;

  always_comb begin
    tail_data = 32'h0;
    tail_mode = M_T0;
    case ({nb[1:0], tidx})
      4'b00_00: begin tail_data = {16'h0, s0, s1}; tail_mode = M_T16; end
      4'b00_01: tail_mode = M_T0;
      4'b00_10: tail_mode = M_T16;
      4'b01_00: begin tail_data = {8'h0, b0, s0, s1}; tail_mode = M_T24; end
      4'b01_01: tail_mode = M_T0;
      4'b01_10: tail_mode = M_T8;
      4'b10_00: begin tail_data = {b0, b1, s0, s1}; tail_mode = M_T32; end
      4'b10_01: tail_mode = M_T0;
      4'b10_10: tail_mode = M_T0;
      4'b11_00: begin tail_data = {b0, b1, b2, s0}; tail_mode = M_T32; end
      4'b11_01: begin tail_data = {24'h0, s1}; tail_mode = M_T8; end
      4'b11_10: tail_mode = M_T0;
      default:  tail_mode = M_T24;
    endcase
  end

  assign tail_last = (tidx == ((nb[1:0] == 2'd3) ? 2'd3 : 2'd2));

  always_comb begin
    word_valid = 1'b0;
    word_data  = 32'h0;
    word_mode  = M_T32;
    case (state)
      S_KEYS: begin word_valid = (nb >= 4'd4); word_data = acc[63:32]; end
      S_TAIL: begin word_valid = 1'b1; word_data = tail_data; word_mode = tail_mode; end
      S_PAD:  word_valid = (wcnt != 4'd15);
      S_LEN:  begin word_valid = 1'b1; word_data = len_bits; end
      S_CMPL: begin word_valid = 1'b1; word_mode = M_CMPL; end
      default: ;
    endcase
  end

  assign key_ready = (state == S_KEYS) && (left != '0) && (nb <= 4'd3);
  assign push      = key_ready && key_valid;
  assign fire      = word_valid && word_ready;
  assign done      = (state == S_DONE);
  assign pass      = pass_q;
  assign err       = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      left   <= '0;
      total  <= '0;
      stat_q <= '0;
      acc    <= '0;
      nb     <= '0;
      tidx   <= '0;
      wcnt   <= '0;
      pass_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (fire && state != S_CMPL) wcnt <= wcnt + 4'd1;
      case (state)
        S_IDLE: if (start) begin
          left   <= dev_count;
          total  <= dev_count;
          stat_q <= dev_status;
          acc    <= '0;
          nb     <= '0;
          wcnt   <= '0;
          tidx   <= '0;
          pass_q <= (dev_count == '0);
          err_q  <= (32'(dev_count) > MAX_COUNT);
          if (dev_count == '0 || 32'(dev_count) > MAX_COUNT) state <= S_DONE;
          else state <= S_KEYS;
        end
        S_KEYS: begin
          if (push) begin
            acc  <= acc | ({key_data, 24'h0} >> {nb, 3'b000});
            nb   <= nb + 4'd5;
            left <= left - 1'b1;
          end else if (fire) begin
            acc <= acc << 32;
            nb  <= nb - 4'd4;
          end else if (left == '0 && nb < 4'd4) begin
            state <= S_TAIL;
            tidx  <= '0;
          end
        end
        S_TAIL: if (fire) begin
          if (tail_last) state <= S_PAD;
          else tidx <= tidx + 2'd1;
        end
        S_PAD:  if (wcnt == 4'd15) state <= S_LEN;
        S_LEN:  if (fire) state <= S_CMPL;
        S_CMPL: if (fire) state <= S_WAIT;
        S_WAIT: if (hash_done) begin
          pass_q <= hash_match;
          state  <= S_DONE;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (word_mode != 3'd0 && word_mode != 3'd3));

  p_key_word_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    key_ready |-> !word_valid);

  p_cmpl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_mode == M_CMPL) |-> (word_data == 32'h0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data) && $stable(word_mode)));

  p_result_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(pass && err));

endmodule

// File: tb/test_hash_msg_packer.sv
module test_hash_msg_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  dev_count = '0;
  logic [15:0] dev_status = '0;
  logic        key_valid = 1'b0;
  logic [39:0] key_data = '0;
  logic        key_ready;
  logic        word_valid;
  logic        word_ready = 1'b0;
  logic [31:0] word_data;
  logic [2:0]  word_mode;
  logic        hash_done = 1'b0;
  logic        hash_match = 1'b0;
  logic        done, pass, err;

  always #5 clk = ~clk;

  hash_msg_packer i_hash_msg_packer (
    .clk, .rst_n, .start, .dev_count, .dev_status, .key_valid, .key_data,
    .key_ready, .word_valid, .word_ready, .word_data, .word_mode,
    .hash_done, .hash_match, .done, .pass, .err);

  int checks = 0;
  int fails  = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] exp_d [0:255];
  logic [2:0]  exp_m [0:255];
  logic [7:0]  kb [0:639];
  int nw;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [39:0] key_of(input int i);
    return {8'(i*37+5), 8'(i*11+200), 8'(i ^ 8'h5a), 8'(i*3+1), 8'(255-i)};
  endfunction

  task automatic put(input logic [31:0] d, input logic [2:0] m);
    exp_d[nw] = d; exp_m[nw] = m; nw++;
  endtask

  task automatic build(input int n, input logic [15:0] st);
    int nbytes, lo, base;
    nw = 0;
    if (n == 0 || n > 127) return;
    for (int i = 0; i < n; i++) begin
      logic [39:0] k;
      k = key_of(i);
      for (int j = 0; j < 5; j++) kb[i*5+j] = k[39-8*j -: 8];
    end
    nbytes = n * 5;
    for (int w = 0; w < nbytes / 4; w++) put({kb[4*w], kb[4*w+1], kb[4*w+2], kb[4*w+3]}, 3'd1);
    lo = nbytes % 4;
    base = nbytes - lo;
    case (lo)
      0: begin put({16'h0, st}, 3'd5); put(0, 3'd7); put(0, 3'd5); end
      1: begin put({8'h0, kb[base], st}, 3'd4); put(0, 3'd7); put(0, 3'd6); end
      2: begin put({kb[base], kb[base+1], st}, 3'd1); put(0, 3'd7); put(0, 3'd7); end
      default: begin
        put({kb[base], kb[base+1], kb[base+2], st[15:8]}, 3'd1);
        put({24'h0, st[7:0]}, 3'd6); put(0, 3'd7); put(0, 3'd4);
      end
    endcase
    while (nw % 16 != 15) put(0, 3'd1);
    put(32'((n * 5 + 10) * 8), 3'd1);
    put(0, 3'd2);
  endtask

  function automatic string tail_req(input int n, input int idx);
    int lo;
    lo = (n * 5) % 4;
    if (idx < (n * 5) / 4) return "R1";
    if (idx < (n * 5) / 4 + ((lo == 3) ? 4 : 3))
      return (lo == 0) ? "R2" : (lo == 1) ? "R3" : (lo == 2) ? "R4" : "R5";
    if (idx >= nw - 2) return (idx == nw - 1) ? "R7" : "R6";
    return "R6";
  endfunction

  task automatic run(input int n, input logic [15:0] st, input bit m, input bit stall);
    int kidx, widx, hd_cnt;
    bit kfire, held, sent, finished;
    logic [31:0] hd;
    logic [2:0] hm;
    build(n, st);
    @(negedge clk);
    start = 1'b1; dev_count = 8'(n); dev_status = st;
    @(negedge clk);
    start = 1'b0;
    kidx = 0; widx = 0; hd_cnt = -1; kfire = 0; held = 0; sent = 0; finished = 0;
    hd = '0; hm = '0;
    for (int cyc = 0; cyc < 5000 && !finished; cyc++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (kfire) kidx++;
      if (held) chk(word_valid && word_data == hd && word_mode == hm, "R10 held word",
                    {29'h0, word_mode, word_data}, {29'h0, hm, hd});
      hash_done = 1'b0;
      if (done) begin
        finished = 1;
        chk(widx == nw, (n > 127) ? "R9 word count" : (n == 0) ? "R8 word count" : "R7 word count",
            64'(widx), 64'(nw));
        if (n > 127) begin
          chk(err && !pass, "R9 err result", {pass, err}, 2'b01);
          chk(kidx == 0, "R9 no key taken", 64'(kidx), 0);
        end else if (n == 0) begin
          chk(pass && !err, "R8 pass result", {pass, err}, 2'b10);
          chk(kidx == 0, "R8 no key taken", 64'(kidx), 0);
        end else begin
          chk(sent, "R7 done after hash_done", 64'(sent), 1);
          chk(pass == m && !err, "R7 pass from match", {pass, err}, {m, 1'b0});
          chk(kidx == n, "R1 keys consumed", 64'(kidx), 64'(n));
        end
      end else begin
        if (hd_cnt > 0) hd_cnt--;
        else if (hd_cnt == 0) begin hash_done = 1'b1; hash_match = m; sent = 1; hd_cnt = -1; end
        key_valid = (kidx < n) && (lfsr[2] | lfsr[5]);
        key_data  = key_of(kidx);
        kfire     = key_valid && key_ready;
        word_ready = stall ? (lfsr[0] | lfsr[7]) : 1'b1;
        held = 0;
        if (word_valid) begin
          if (word_ready) begin
            if (widx < nw)
              chk(word_data == exp_d[widx] && word_mode == exp_m[widx], tail_req(n, widx),
                  {29'h0, word_mode, word_data}, {29'h0, exp_m[widx], exp_d[widx]});
            else chk(1'b0, "R7 extra word", {29'h0, word_mode, word_data}, 0);
            if (word_mode == 3'd2) hd_cnt = 3;
            widx++;
          end else begin
            held = 1; hd = word_data; hm = word_mode;
          end
        end
      end
      @(negedge clk);
    end
    key_valid = 1'b0; word_ready = 1'b0; hash_done = 1'b0;
    if (!finished) chk(1'b0, "R7 run timeout", 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!word_valid && !key_ready && !done, "R11 reset state",
        {word_valid, key_ready, done}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!word_valid && !key_ready && !done, "R11 idle after reset",
        {word_valid, key_ready, done}, 3'b000);
    run(0, 16'h1234, 1'b1, 1'b0);
    for (int n = 1; n <= 40; n++) run(n, 16'(n * 16'h0913 + 16'h2a), n[0], n[1]);
    run(127, 16'hBEEF, 1'b1, 1'b1);
    run(127, 16'h0F0F, 1'b0, 1'b0);
    run(128, 16'h5555, 1'b1, 1'b1);
    run(200, 16'hAAAA, 1'b1, 1'b0);
    run(5, 16'hC3C3, 1'b0, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule